// File: doc/BRIEF.md
# VLIW Group Operand Fetch and Result Conditioning

This block prepares the operands of one five-slot ALU instruction group and conditions the results. Four vector lanes (X, Y, Z, W) and one transcendental slot (Trans, slot 4) each carry one source descriptor. A source reads one of several places: the general register file (128 words), the constant bank (256 words), the value the same-or-another slot produced in the previous committed group, one of the literals sent with the group, or a built-in constant. The block then applies absolute value and negation to the operand. Every slot's operation is a pass-through of its operand, because the arithmetic units are outside this block. An output scale and a clamp condition each result. The result is then written to the register file and kept as that slot's previous result.

A group is offered with a one-cycle `grp_valid_i` pulse. A controller with four named states handles it. The states are `ST_IDLE`, `ST_DECODE`, `ST_COMMIT` and `ST_REJECT`, joined by these transitions:
- accept: `ST_IDLE` to `ST_DECODE` when `grp_valid_i` is high.
- commit: `ST_DECODE` to `ST_COMMIT` when the group is legal.
- reject: `ST_DECODE` to `ST_REJECT` when the group is illegal.
- retire: `ST_COMMIT` to `ST_IDLE`.
- recover: `ST_REJECT` to `ST_IDLE`.

All writes happen on the commit edge. A rejected group changes nothing. The constant bank is loaded through a separate write port.

Top module: `vliw_operand_stage`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `illegal_o`, `res_valid_o` and `res_data_o` are zero. Every register-file word, constant word and previous result is 0.
- R2: A `grp_valid_i` pulse is taken only in idle. `busy_o` rises one cycle after the accepting edge. `done_o` (or `illegal_o`) is high for exactly the second cycle after it. The block is idle in the third cycle. `grp_valid_i` has no effect while busy.
- R3: Slot s descriptor sits at bits [27s+26:27s] of `grp_slots_i`. Its fields are, LSB first: enable[0], op[3:1], kind[6:4], index[14:7], abs[15], neg[16], dst[23:17], scale[25:24] and clamp[26]. Kind 0 reads register `index`. Kind 1 reads constant `index`.
- R4: Kind 2 reads the result that slot `index` (0..4) produced in the most recent committed group.
- R5: Kind 3 reads literal `index`, where literal i is `grp_lits_i[32i+31:32i]`. The literal count code `grp_lit_cnt_i` is 0, 1 or 2, giving 0, 2 or 4 literals.
- R6: Kind 4 yields a built-in value by `index`: 0 gives 0x00000000, 1 gives 0x3F000000, 2 gives 0x3F800000, 3 gives 0xFFFFFFFF, 4 gives 0x00000000 and 5 gives 0x00000001.
- R7: Only bit 31 of the operand changes. Abs clears it, then neg inverts it, so both set give a set sign.
- R8: The scale code adds 0, +1, +2 or -1 to the exponent for codes 0, 1, 2 and 3. Exponents 0 and 255 pass unchanged. An overflow gives a signed infinity. A result exponent of 0 or below gives a signed zero.
- R9: Clamp, applied after scaling, maps NaN and any value with the sign set to 0x00000000. Values at or above 1.0 become 0x3F800000.
- R10: Op codes: 0 is a move allowed in any slot. 1 and 2 are four-lane operations allowed in slots 0..3 only. 3, 4 and 5 are shift, conversion and transcendental operations allowed in slot 4 only. Codes 6 and 7 are never allowed.
- R11: An enabled slot makes the group illegal if any of these holds: the literal index is at or above the count, the literal count code is 3, the kind is 5..7, the built-in index is above 5, the previous-slot index is above 4, or the register index is above 127. An illegal group pulses `illegal_o` and writes no register, previous result or output.
- R12: All sources read the state from before the group. When several slots write one register, the highest-numbered slot wins.
- R13: A constant write (`cb_we_i`) is taken on any clock edge. It is visible to groups decoded afterwards.
- R14: A disabled slot writes nothing, keeps its previous result and shows 0 in `res_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid_i | input | 1 | Offer a group |
| grp_slots_i | input | 135 | Five slot descriptors |
| grp_lit_cnt_i | input | 2 | Literal count code |
| grp_lits_i | input | 128 | Four literal words |
| cb_we_i | input | 1 | Constant bank write enable |
| cb_addr_i | input | 8 | Constant bank write address |
| cb_wdata_i | input | 32 | Constant bank write data |
| busy_o | output | 1 | Group in flight |
| done_o | output | 1 | Group committed (one cycle) |
| illegal_o | output | 1 | Group rejected (one cycle) |
| res_valid_o | output | 5 | Slots that produced results, during `done_o` |
| res_data_o | output | 160 | Conditioned results, slot s at [32s+31:32s] |

## Verification
The assertions check these properties on every cycle:
- `done_o` and `illegal_o` never coincide.
- Acceptance raises busy, and commit returns the block to idle.
- A rejection leaves the outputs untouched.
- Only the sign bit changes in the modifier.
- A clamped result lies in [0, 1.0].
- Scaling a normal number keeps its mantissa.

Only the bench scenarios can show the following:
- Operand values are taken from the right register, constant, literal or previous result.
- The built-in constants are correct.
- The slot placement rules hold.
- A rejected group leaves the register file unchanged.
- The highest-numbered slot wins a write conflict.

// File: rtl/vliw_pkg.sv
package vliw_pkg;

    localparam int NUM_SLOTS  = 5;
    localparam int WORD_W     = 32;
    localparam int IDX_W      = 8;
    localparam int DST_W      = 7;
    localparam int MAX_LIT    = 4;
    localparam int SLOT_W     = 27;
    localparam int TRANS_SLOT = 4;

    // source kinds
    localparam logic [2:0] K_GPR   = 3'd0;
    localparam logic [2:0] K_CONST = 3'd1;
    localparam logic [2:0] K_PREV  = 3'd2;
    localparam logic [2:0] K_LIT   = 3'd3;
    localparam logic [2:0] K_INL   = 3'd4;

    // operation classes
    localparam logic [2:0] OP_MOV    = 3'd0;
    localparam logic [2:0] OP_DOT4   = 3'd1;
    localparam logic [2:0] OP_MAX4   = 3'd2;
    localparam logic [2:0] OP_SHIFT  = 3'd3;
    localparam logic [2:0] OP_CVT    = 3'd4;
    localparam logic [2:0] OP_TRANSC = 3'd5;

    localparam logic [WORD_W-1:0] F_ZERO = 32'h0000_0000;
    localparam logic [WORD_W-1:0] F_HALF = 32'h3F00_0000;
    localparam logic [WORD_W-1:0] F_ONE  = 32'h3F80_0000;

    typedef struct packed {
        logic             clamp;
        logic [1:0]       omod;
        logic [DST_W-1:0] dst;
        logic             neg;
        logic             abs_f;
        logic [IDX_W-1:0] idx;
        logic [2:0]       kind;
        logic [2:0]       op;
        logic             en;
    } slot_t;

endpackage

// File: rtl/vliw_slot_check.sv
module vliw_slot_check
    import vliw_pkg::*;
#(
    parameter bit IS_TRANS  = 1'b0,
    parameter int NUM_GPR   = 128,
    parameter int NUM_CONST = 256
) (
    input  logic             en,
    input  logic [2:0]       op,
    input  logic [2:0]       kind,
    input  logic [IDX_W-1:0] idx,
    input  logic [DST_W-1:0] dst,
    input  logic [1:0]       lit_cnt,
    output logic             bad
);
    logic op_ok;
    logic src_ok;
    logic dst_ok;
    int   lit_n;

    always_comb begin
        unique case (lit_cnt)
            2'd0:    lit_n = 0;
            2'd1:    lit_n = 2;
            default: lit_n = 4;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_MOV:                       op_ok = 1'b1;
            OP_DOT4, OP_MAX4:             op_ok = !IS_TRANS;
            OP_SHIFT, OP_CVT, OP_TRANSC:  op_ok = IS_TRANS;
            default:                      op_ok = 1'b0;
        endcase
    end

    always_comb begin
        unique case (kind)
            K_GPR:   src_ok = int'(idx) < NUM_GPR;
            K_CONST: src_ok = int'(idx) < NUM_CONST;
            K_PREV:  src_ok = int'(idx) < NUM_SLOTS;
            K_LIT:   src_ok = int'(idx) < lit_n;
            K_INL:   src_ok = int'(idx) <= 5;
            default: src_ok = 1'b0;
        endcase
    end

    assign dst_ok = int'(dst) < NUM_GPR;
    assign bad    = en && !(op_ok && src_ok && dst_ok);

endmodule

// File: rtl/vliw_src_fetch.sv
module vliw_src_fetch
    import vliw_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  kind,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        abs_f,
    input  logic                        neg,
    input  logic [WORD_W-1:0]           gpr_rd,
    input  logic [WORD_W-1:0]           const_rd,
    input  logic [NUM_SLOTS*WORD_W-1:0] prev_flat,
    input  logic [MAX_LIT*WORD_W-1:0]   lit_flat,
    output logic [WORD_W-1:0]           operand
);
    logic [WORD_W-1:0] prev_sel;
    logic [WORD_W-1:0] lit_sel;
    logic [WORD_W-1:0] inl_val;
    logic [WORD_W-1:0] raw;

    always_comb begin
        prev_sel = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (int'(idx) == s) prev_sel = prev_flat[s*WORD_W +: WORD_W];
    end

    always_comb begin
        lit_sel = '0;
        for (int l = 0; l < MAX_LIT; l++)
            if (int'(idx) == l) lit_sel = lit_flat[l*WORD_W +: WORD_W];
    end

    always_comb begin
        unique case (idx)
            8'd1:    inl_val = F_HALF;
            8'd2:    inl_val = F_ONE;
            8'd3:    inl_val = '1;
            8'd5:    inl_val = 32'd1;
            default: inl_val = F_ZERO;
        endcase
    end

    always_comb begin
        unique case (kind)
            K_GPR:   raw = gpr_rd;
            K_CONST: raw = const_rd;
            K_PREV:  raw = prev_sel;
            K_LIT:   raw = lit_sel;
            default: raw = inl_val;
        endcase
    end

    // abs first, then negate: both set yields a negative magnitude
    assign operand = {abs_f ? neg : (raw[WORD_W-1] ^ neg), raw[WORD_W-2:0]};

    // R7
    magnitude_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        operand[WORD_W-2:0] == raw[WORD_W-2:0]);
    // R7
    abs_neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abs_f && neg) |-> operand[WORD_W-1]);

endmodule

// File: rtl/vliw_out_mod.sv
module vliw_out_mod
    import vliw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] d,
    input  logic [1:0]        omod,
    input  logic              clamp,
    output logic [WORD_W-1:0] q
);
    logic [7:0]        exp_in;
    logic signed [9:0] delta;
    logic signed [9:0] exp_new;
    logic              special;
    logic [WORD_W-1:0] scaled;
    logic              is_nan;

    assign exp_in  = d[30:23];
    assign special = (exp_in == 8'h00) || (exp_in == 8'hFF);

    always_comb begin
        unique case (omod)
            2'd1:    delta = 10'sd1;
            2'd2:    delta = 10'sd2;
            2'd3:    delta = -10'sd1;
            default: delta = 10'sd0;
        endcase
    end

    assign exp_new = $signed({2'b00, exp_in}) + delta;

    always_comb begin
        if (special || omod == 2'd0)
            scaled = d;
        else if (exp_new >= 10'sd255)
            scaled = {d[31], 8'hFF, 23'd0};
        else if (exp_new <= 10'sd0)
            scaled = {d[31], 31'd0};
        else
            scaled = {d[31], exp_new[7:0], d[22:0]};
    end

    assign is_nan = (scaled[30:23] == 8'hFF) && (scaled[22:0] != 23'd0);

    always_comb begin
        if (!clamp)
            q = scaled;
        else if (is_nan || scaled[31])
            q = F_ZERO;
        else if (scaled[30:0] >= F_ONE[30:0])
            q = F_ONE;
        else
            q = scaled;
    end

    // R9
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp |-> (!q[31] && q <= F_ONE));
    // R8
    scale_mantissa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clamp && omod != 2'd0 && exp_in > 8'd1 && exp_in < 8'd250)
            |-> (q[22:0] == d[22:0]));

endmodule

// File: rtl/vliw_operand_stage.sv
module vliw_operand_stage
    import vliw_pkg::*;
#(
    parameter int NUM_GPR   = 128,
    parameter int NUM_CONST = 256,
    localparam int GPR_AW   = $clog2(NUM_GPR),
    localparam int CONST_AW = $clog2(NUM_CONST)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        grp_valid_i,
    input  logic [NUM_SLOTS*SLOT_W-1:0] grp_slots_i,
    input  logic [1:0]                  grp_lit_cnt_i,
    input  logic [MAX_LIT*WORD_W-1:0]   grp_lits_i,
    input  logic                        cb_we_i,
    input  logic [CONST_AW-1:0]         cb_addr_i,
    input  logic [WORD_W-1:0]           cb_wdata_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        illegal_o,
    output logic [NUM_SLOTS-1:0]        res_valid_o,
    output logic [NUM_SLOTS*WORD_W-1:0] res_data_o
);
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_COMMIT,
        ST_REJECT
    } state_e;

    state_e state_q, state_d;

    slot_t                       slot_q [NUM_SLOTS];
    logic [1:0]                  lit_cnt_q;
    logic [MAX_LIT*WORD_W-1:0]   lits_q;
    logic [WORD_W-1:0]           gpr   [NUM_GPR];
    logic [WORD_W-1:0]           cbank [NUM_CONST];
    logic [NUM_SLOTS*WORD_W-1:0] prev_q;
    logic [NUM_SLOTS*WORD_W-1:0] res_q;
    logic [NUM_SLOTS-1:0]        res_valid_q;
    logic [NUM_SLOTS-1:0]        slot_bad;
    logic [NUM_SLOTS-1:0]        en_vec;
    logic [WORD_W-1:0]           result [NUM_SLOTS];
    logic                        grp_bad;
    logic                        accept;
    logic                        commit;

    assign accept  = (state_q == ST_IDLE) && grp_valid_i;
    assign grp_bad = (lit_cnt_q == 2'd3) || (|slot_bad);
    assign commit  = (state_q == ST_DECODE) && !grp_bad;

    // group capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) slot_q[s] <= '0;
            lit_cnt_q <= '0;
            lits_q    <= '0;
        end else if (accept) begin
            for (int s = 0; s < NUM_SLOTS; s++)
                slot_q[s] <= slot_t'(grp_slots_i[s*SLOT_W +: SLOT_W]);
            lit_cnt_q <= grp_lit_cnt_i;
            lits_q    <= grp_lits_i;
        end
    end

    // per-slot datapath
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [WORD_W-1:0] operand;
        logic [WORD_W-1:0] gpr_rd;
        logic [WORD_W-1:0] const_rd;

        assign gpr_rd    = gpr[slot_q[s].idx[GPR_AW-1:0]];
        assign const_rd  = cbank[slot_q[s].idx[CONST_AW-1:0]];
        assign en_vec[s] = slot_q[s].en;

        vliw_slot_check #(
            .IS_TRANS  (s == TRANS_SLOT),
            .NUM_GPR   (NUM_GPR),
            .NUM_CONST (NUM_CONST)
        ) u_check (
            .en      (slot_q[s].en),
            .op      (slot_q[s].op),
            .kind    (slot_q[s].kind),
            .idx     (slot_q[s].idx),
            .dst     (slot_q[s].dst),
            .lit_cnt (lit_cnt_q),
            .bad     (slot_bad[s])
        );

        vliw_src_fetch u_fetch (
            .clk       (clk),
            .rst_n     (rst_n),
            .kind      (slot_q[s].kind),
            .idx       (slot_q[s].idx),
            .abs_f     (slot_q[s].abs_f),
            .neg       (slot_q[s].neg),
            .gpr_rd    (gpr_rd),
            .const_rd  (const_rd),
            .prev_flat (prev_q),
            .lit_flat  (lits_q),
            .operand   (operand)
        );

        // every operation class passes its operand through
        vliw_out_mod u_omod (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (operand),
            .omod  (slot_q[s].omod),
            .clamp (slot_q[s].clamp),
            .q     (result[s])
        );
    end

    // register file: ascending loop, so the highest slot wins a shared dst
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GPR; i++) gpr[i] <= '0;
        end else if (commit) begin
            for (int s = 0; s < NUM_SLOTS; s++)
                if (slot_q[s].en) gpr[slot_q[s].dst[GPR_AW-1:0]] <= result[s];
        end
    end

    // constant bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CONST; i++) cbank[i] <= '0;
        end else if (cb_we_i) begin
            cbank[cb_addr_i] <= cb_wdata_i;
        end
    end

    // previous results and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= '0;
            res_q       <= '0;
            res_valid_q <= '0;
        end else if (commit) begin
            res_valid_q <= en_vec;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (slot_q[s].en) begin
                    prev_q[s*WORD_W +: WORD_W] <= result[s];
                    res_q[s*WORD_W +: WORD_W]  <= result[s];
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (grp_valid_i) state_d = ST_DECODE;
            ST_DECODE: state_d = grp_bad ? ST_REJECT : ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o      = 1'b0;
        done_o      = 1'b0;
        illegal_o   = 1'b0;
        res_valid_o = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_DECODE: busy_o = 1'b1;
            ST_COMMIT: begin
                busy_o      = 1'b1;
                done_o      = 1'b1;
                res_valid_o = res_valid_q;
            end
            ST_REJECT: begin
                busy_o    = 1'b1;
                illegal_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign res_data_o = res_q;

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && grp_valid_i) |=> busy_o);
    // R2
    retire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || illegal_o) |=> !busy_o);
    // R2
    done_illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && illegal_o));
    // R11
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($stable(res_data_o) && res_valid_o == '0));

endmodule

// File: tb/vliw_operand_stage_test.sv
module vliw_operand_stage_test;
    import vliw_pkg::*;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         grp_valid_i = 1'b0;
    logic [134:0] grp_slots_i = '0;
    logic [1:0]   grp_lit_cnt_i = '0;
    logic [127:0] grp_lits_i = '0;
    logic         cb_we_i = 1'b0;
    logic [7:0]   cb_addr_i = '0;
    logic [31:0]  cb_wdata_i = '0;
    logic         busy_o, done_o, illegal_o;
    logic [4:0]   res_valid_o;
    logic [159:0] res_data_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [26:0]  sl [5];
    logic [1:0]   lc;
    logic [31:0]  lits [4];
    logic         g_done, g_ill;
    logic [4:0]   g_rv;
    logic [159:0] g_res;

    vliw_operand_stage uut (.*);

    always #2 clk = ~clk;

    function automatic logic [26:0] mk(bit en, int op, int kind, int idx,
                                       bit ab, bit ng, int dst, int om, bit cl);
        return {cl, om[1:0], dst[6:0], ng, ab, idx[7:0], kind[2:0], op[2:0], en};
    endfunction

    function automatic logic [31:0] inl_model(int code);
        case (code)
            1: return 32'h3F00_0000;
            2: return 32'h3F80_0000;
            3: return 32'hFFFF_FFFF;
            5: return 32'h0000_0001;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] cond_model(logic [31:0] v, int om, bit cl);
        logic [31:0] r;
        int e, k;
        r = v;
        e = int'(v[30:23]);
        if (om != 0 && e != 0 && e != 255) begin
            k = (om == 1) ? 1 : (om == 2) ? 2 : -1;
            if (e + k > 254)    r = {v[31], 8'hFF, 23'h0};
            else if (e + k < 1) r = {v[31], 31'h0};
            else begin
                e = e + k;
                r = {v[31], e[7:0], v[22:0]};
            end
        end
        if (cl) begin
            if (r[30:23] == 8'hFF && r[22:0] != 0) r = 32'h0;
            else if (r[31])                        r = 32'h0;
            else if (r > 32'h3F80_0000)            r = 32'h3F80_0000;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_group();
        for (int s = 0; s < 5; s++) sl[s] = '0;
        lc = 2'd0;
        for (int l = 0; l < 4; l++) lits[l] = '0;
    endtask

    // accept at edge E0, outputs visible after E1, idle after E2
    task automatic run_group();
        @(negedge clk);
        grp_slots_i   = {sl[4], sl[3], sl[2], sl[1], sl[0]};
        grp_lit_cnt_i = lc;
        grp_lits_i    = {lits[3], lits[2], lits[1], lits[0]};
        grp_valid_i   = 1'b1;
        @(posedge clk); #1;
        grp_valid_i = 1'b0;
        @(posedge clk); #1;
        g_done = done_o;
        g_ill  = illegal_o;
        g_rv   = res_valid_o;
        g_res  = res_data_o;
        @(posedge clk); #1;
    endtask

    task automatic rd_gpr(int idx, output logic [31:0] v);
        clear_group();
        sl[0] = mk(1, 0, 0, idx, 0, 0, 127, 0, 0);
        run_group();
        v = g_res[31:0];
    endtask

    task automatic wr_gpr(int idx, logic [31:0] v);
        clear_group();
        lc = 2'd1;
        lits[0] = v;
        sl[0] = mk(1, 0, 3, 0, 0, 0, idx, 0, 0);
        run_group();
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, e;
        logic [31:0] vals [9];
        vals = '{32'h3FC0_0000, 32'hBF40_0000, 32'h3E99_999A, 32'h0000_0000,
                 32'h7FC0_0000, 32'h7F80_0000, 32'h7F00_0000, 32'h0080_0000,
                 32'h3F19_999A};
        clear_group();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 done/illegal", {done_o, illegal_o}, 0);
        chk("R1 res", {res_valid_o, res_data_o}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        rd_gpr(5, v);
        chk("R1 gpr zero", v, 0);
        clear_group();
        sl[0] = mk(1, 0, 1, 9, 0, 0, 127, 0, 0);
        sl[1] = mk(1, 0, 2, 3, 0, 0, 126, 0, 0);
        run_group();
        chk("R1 const/prev zero", g_res[63:0], 0);

        // R2 timing and ignored valid while busy
        clear_group();
        sl[0] = mk(1, 0, 4, 2, 0, 0, 1, 0, 0);
        @(negedge clk);
        grp_slots_i = {sl[4], sl[3], sl[2], sl[1], sl[0]};
        grp_lit_cnt_i = 0;
        grp_valid_i = 1'b1;
        @(posedge clk); #1;
        chk("R2 busy after accept", {busy_o, done_o}, 2'b10);
        @(posedge clk); #1;
        chk("R2 done second cycle", {done_o, illegal_o}, 2'b10);
        grp_valid_i = 1'b0;
        @(posedge clk); #1;
        chk("R2 idle third cycle, valid while busy ignored", busy_o, 0);
        @(posedge clk); #1;
        chk("R2 no second group", {busy_o, done_o}, 0);

        // R6 built-in constants
        for (int c = 0; c < 6; c++) begin
            clear_group();
            sl[0] = mk(1, 0, 4, c, 0, 0, 10, 0, 0);
            run_group();
            chk("R6 inline", g_res[31:0], inl_model(c));
        end

        // R7 abs/neg combinations
        for (int c = 1; c <= 3; c += 2)
            for (int m = 0; m < 4; m++) begin
                clear_group();
                sl[2] = mk(1, 0, 4, c, m[0], m[1], 11, 0, 0);
                run_group();
                e = inl_model(c);
                e[31] = m[0] ? m[1] : (e[31] ^ m[1]);
                chk("R7 abs/neg", g_res[95:64], e);
            end

        // R5 / R11 literal count and index sweep
        for (int cnt = 0; cnt < 4; cnt++)
            for (int i = 0; i < 4; i++) begin
                clear_group();
                lc = cnt[1:0];
                for (int l = 0; l < 4; l++) lits[l] = 32'h1000_0000 + l * 32'h111;
                sl[1] = mk(1, 0, 3, i, 0, 0, 12, 0, 0);
                run_group();
                if (cnt < 3 && i < 2 * cnt) begin
                    chk("R5 literal value", {g_done, g_res[63:32]}, {1'b1, lits[i]});
                end else begin
                    chk("R11 literal out of count", {g_ill, g_done, g_rv}, {1'b1, 1'b0, 5'b0});
                end
            end

        // R3 register writes from four lanes, then read back
        clear_group();
        lc = 2'd2;
        for (int s = 0; s < 4; s++) begin
            lits[s] = 32'hA000_0000 + s;
            sl[s] = mk(1, 0, 3, s, 0, 0, 20 + s, 0, 0);
        end
        run_group();
        for (int s = 0; s < 4; s++) begin
            rd_gpr(20 + s, v);
            chk("R3 gpr read", v, 32'hA000_0000 + s);
        end

        // R13 constant bank writes and R3 constant reads
        @(negedge clk);
        cb_we_i = 1; cb_addr_i = 8'd200; cb_wdata_i = 32'h1234_5678;
        @(negedge clk);
        cb_addr_i = 8'd255; cb_wdata_i = 32'h8765_4321;
        @(negedge clk);
        cb_we_i = 0;
        clear_group();
        sl[0] = mk(1, 0, 1, 200, 0, 0, 13, 0, 0);
        sl[4] = mk(1, 0, 1, 255, 0, 0, 14, 0, 0);
        run_group();
        chk("R13 const 200", g_res[31:0], 32'h1234_5678);
        chk("R3 const 255", g_res[159:128], 32'h8765_4321);

        // R4 previous results
        clear_group();
        lc = 2'd2;
        for (int s = 0; s < 4; s++) begin
            lits[s] = 32'hB000_0000 + s;
            sl[s] = mk(1, 0, 3, s, 0, 0, 60 + s, 0, 0);
        end
        sl[4] = mk(1, 0, 4, 2, 0, 0, 64, 0, 0);
        run_group();
        clear_group();
        for (int s = 0; s < 5; s++) sl[s] = mk(1, 0, 2, 4 - s, 0, 0, 70 + s, 0, 0);
        run_group();
        chk("R4 prev reversed",
            g_res, {32'hB000_0000, 32'hB000_0001, 32'hB000_0002, 32'hB000_0003, 32'h3F80_0000});

        // R14 disabled slots keep previous results
        clear_group();
        sl[0] = mk(1, 0, 4, 0, 0, 0, 75, 0, 0);
        run_group();
        chk("R14 valid mask", g_rv, 5'b00001);
        clear_group();
        sl[0] = mk(1, 0, 2, 0, 0, 0, 76, 0, 0);
        sl[1] = mk(1, 0, 2, 3, 0, 0, 77, 0, 0);
        sl[2] = mk(1, 0, 2, 4, 0, 0, 78, 0, 0);
        run_group();
        chk("R14 prev kept", g_res[95:0], {32'hB000_0000, 32'hB000_0001, 32'h0});

        // R8 / R9 scale and clamp sweep
        foreach (vals[k])
            for (int om = 0; om < 4; om++)
                for (int cl = 0; cl < 2; cl++) begin
                    clear_group();
                    lc = 2'd1;
                    lits[0] = vals[k];
                    sl[0] = mk(1, 0, 3, 0, 0, 0, 15, om, cl[0]);
                    run_group();
                    chk(cl ? "R9 clamp" : "R8 scale", g_res[31:0], cond_model(vals[k], om, cl[0]));
                end

        // R10 slot placement sweep
        for (int op = 0; op < 8; op++)
            for (int s = 0; s < 5; s++) begin
                bit legal;
                clear_group();
                sl[s] = mk(1, op, 4, 2, 0, 0, 90 + s, 0, 0);
                run_group();
                legal = (op == 0) || ((op == 1 || op == 2) && s < 4) ||
                        (op >= 3 && op <= 5 && s == 4);
                if (legal)
                    chk("R10 legal placement", {g_done, g_ill, g_rv, g_res[s*32 +: 32]},
                        {2'b10, 5'(1 << s), 32'h3F80_0000});
                else
                    chk("R10 illegal placement", {g_done, g_ill, g_rv}, {2'b01, 5'b0});
            end

        // R11 malformed sources
        for (int t = 0; t < 4; t++) begin
            clear_group();
            case (t)
                0: sl[0] = mk(1, 0, 5, 0, 0, 0, 16, 0, 0);
                1: sl[0] = mk(1, 0, 4, 6, 0, 0, 16, 0, 0);
                2: sl[0] = mk(1, 0, 2, 5, 0, 0, 16, 0, 0);
                default: sl[0] = mk(1, 0, 0, 128, 0, 0, 16, 0, 0);
            endcase
            run_group();
            chk("R11 bad source", {g_done, g_ill}, 2'b01);
        end

        // R11 rejected group writes nothing
        wr_gpr(40, 32'hAAAA_5555);
        clear_group();
        lc = 2'd1;
        lits[0] = 32'h1234_5678;
        sl[0] = mk(1, 0, 3, 0, 0, 0, 40, 0, 0);
        sl[1] = mk(1, 3, 4, 1, 0, 0, 41, 0, 0);
        run_group();
        chk("R11 rejected", {g_done, g_ill}, 2'b01);
        clear_group();
        sl[0] = mk(1, 0, 2, 0, 0, 0, 127, 0, 0);
        run_group();
        chk("R11 prev untouched", g_res[31:0], 32'hAAAA_5555);
        rd_gpr(40, v);
        chk("R11 gpr untouched", v, 32'hAAAA_5555);

        // R12 write conflict and read-before-write
        clear_group();
        lc = 2'd1;
        lits[0] = 32'h0000_0111;
        lits[1] = 32'h0000_0333;
        sl[0] = mk(1, 0, 3, 0, 0, 0, 50, 0, 0);
        sl[3] = mk(1, 0, 3, 1, 0, 0, 50, 0, 0);
        run_group();
        rd_gpr(50, v);
        chk("R12 highest slot wins", v, 32'h0000_0333);
        clear_group();
        sl[0] = mk(1, 0, 0, 50, 0, 0, 51, 0, 0);
        sl[1] = mk(1, 0, 4, 5, 0, 0, 50, 0, 0);
        run_group();
        chk("R12 read sees old value", g_res[31:0], 32'h0000_0333);
        rd_gpr(50, v);
        chk("R12 new value written", v, 32'h1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule